// File: doc/BRIEF.md
# Timer-Paced Serial Shift Register

This block is an 8-bit serial shifter whose bit clock comes from a reloading 8-bit down-counter rather than from the system clock. Each time the counter times out, the shift clock output toggles. Two timeouts make one bit: one low phase and one high phase of the shift clock. With a rate value N, one timeout lasts N+2 system clocks, so one bit lasts 2*(N+2) clocks. In free-running mode the byte circulates without end. On a square-wave pattern such as 0x0F this gives a tone at clk / (16*(N+2)).

A host reaches the block through a small register port with three registers: mode, rate and data. Every register access is a single-cycle strobe with no back-pressure. The serial pins are plain level signals, so no valid/ready handshake applies to them. Two timer-controlled modes shift exactly one byte, out or in, and then raise a completion flag. Touching the data register clears that flag.

Top module: `sts_timed_shifter`

## Requirements
- R1: Register select `bus_addr`: 0 = mode, 1 = rate N, 2 = data, 3 reads as 0. A read returns its value on `bus_rdata` one cycle after the `bus_rd` strobe. The mode field is bits [4:2] of the mode register: 3'b100 (mode byte 0x10) is free-running shift-out, 3'b101 (0x14) is timer-controlled shift-out, 3'b001 (0x04) is timer-controlled shift-in, and every other value is idle.
- R2: The first timeout comes N+2 clocks after the data access that starts shifting. The counter then reloads from the rate register, and timeouts repeat every N+2 clocks, for N from 0 to 255.
- R3: `shclk_o` is high while idle. Each timeout toggles it, and the first toggle after a start is a falling one.
- R4: The data register shifts left once per bit, on the rising timeouts, so consecutive shifts are 2*(N+2) clocks apart. In the shift-out modes the MSB re-enters at the LSB.
- R5: `shdat_o` takes the data register MSB on each falling edge of `shclk_o` and changes at no other time.
- R6: In the timer-controlled modes, shifting stops after 8 bits. `shdone_o` then rises on the same cycle as the eighth rising edge, and `shclk_o` stays high afterwards.
- R7: Free-running mode never stops and never raises `shdone_o`.
- R8: A data write in any shifting mode starts shifting. A data read starts shifting only in the timer-controlled modes. Any data read or data write clears `shdone_o`.
- R9: In shift-in mode, `ser_in` is sampled into the LSB on each rising edge of `shclk_o`, and after 8 bits the data register holds the received byte, MSB first.
- R10: A mode write halts shifting at once and returns `shclk_o` high. A data write in an idle mode only loads the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after `bus_rd` |
| ser_in | input | 1 | Serial data input for shift-in |
| shclk_o | output | 1 | Shift clock output |
| shdat_o | output | 1 | Serial data output |
| shdone_o | output | 1 | Byte-complete flag for the timer-controlled modes |

## Verification
On every cycle, the assertions check the following:
- two timeouts never fall on consecutive cycles;
- the clock rests high whenever shifting is stopped;
- the serial output changes only on a falling shift clock;
- the register shifts only on a rising shift clock;
- a completion stops the clock high;
- a data access always leaves the flag clear.

Only the bench scenarios can show the absolute timing: first and repeated half-periods of exactly N+2 clocks for N = 0, 1, 5 and 255, bit order and recirculation of whole patterns, the eight-bit stop, the byte received in shift-in, and restart by a read.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic [1:0] {
    RG_MODE = 2'd0,
    RG_RATE = 2'd1,
    RG_DATA = 2'd2,
    RG_NONE = 2'd3
  } reg_sel_e;

  localparam logic [2:0] SM_FREE_OUT = 3'b100;
  localparam logic [2:0] SM_CTRL_OUT = 3'b101;
  localparam logic [2:0] SM_CTRL_IN  = 3'b001;

  function automatic logic is_free(input logic [2:0] m);
    return m == SM_FREE_OUT;
  endfunction

  function automatic logic is_ctrl(input logic [2:0] m);
    return (m == SM_CTRL_OUT) || (m == SM_CTRL_IN);
  endfunction

  function automatic logic is_shifting(input logic [2:0] m);
    return is_free(m) || is_ctrl(m);
  endfunction
endpackage

// File: rtl/sts_rate_timer.sv
module sts_rate_timer #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [RW-1:0] latch,
  output logic          tmo
);
  logic [RW:0] cnt;
  logic [RW:0] reload;

  assign reload = {1'b0, latch} + {{RW{1'b0}}, 1'b1};
  assign tmo    = run && !restart && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= reload;
    else if (run) begin
      if (cnt == '0)   cnt <= reload;
      else             cnt <= cnt - 1'b1;
    end
  end

  // R2: reload is at least 1, so a timeout is never followed by another at once
  p_no_back_to_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !tmo);
endmodule

// File: rtl/sts_bit_engine.sv
module sts_bit_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop,
  input  logic         start,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr_done,
  input  logic         tmo,
  input  logic         free_run,
  input  logic         shift_in,
  input  logic         sin,
  output logic [W-1:0] sr,
  output logic         sclk,
  output logic         sout,
  output logic         run,
  output logic         done
);
  localparam int BCW = (W > 1) ? $clog2(W) : 1;
  localparam logic [BCW-1:0] LAST = BCW'(W - 1);

  logic [BCW-1:0] bitcnt;
  logic [W-1:0]   sr_next;

  always_comb begin
    if (shift_in) sr_next = {sr[W-2:0], sin};
    else          sr_next = {sr[W-2:0], sr[W-1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr     <= '0;
      sclk   <= 1'b1;
      sout   <= 1'b0;
      run    <= 1'b0;
      done   <= 1'b0;
      bitcnt <= '0;
    end else begin
      if (stop) begin
        run    <= 1'b0;
        sclk   <= 1'b1;
        bitcnt <= '0;
      end else if (start || load) begin
        if (load) sr <= load_val;
        if (start) begin
          run    <= 1'b1;
          sclk   <= 1'b1;
          bitcnt <= '0;
        end
      end else if (tmo && run) begin
        if (sclk) begin
          sclk <= 1'b0;
          if (!shift_in) sout <= sr[W-1];
        end else begin
          sclk <= 1'b1;
          sr   <= sr_next;
          if (!free_run) begin
            if (bitcnt == LAST) begin
              run    <= 1'b0;
              done   <= 1'b1;
              bitcnt <= '0;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
      end
      if (clr_done) done <= 1'b0;
    end
  end

  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> sclk);
  p_cb2_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sout) |-> $fell(sclk));
  p_shift_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sr) && !$past(load)) |-> $rose(sclk));
  p_done_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!run && sclk));
endmodule

// File: rtl/sts_timed_shifter.sv
module sts_timed_shifter
  import sts_pkg::*;
#(
  parameter int DW = 8,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          ser_in,
  output logic          shclk_o,
  output logic          shdat_o,
  output logic          shdone_o
);
  logic [7:0]    mode_q;
  logic [RW-1:0] rate_q;
  logic [DW-1:0] sr;
  logic [2:0]    mfield;
  logic          wr_mode, wr_rate, wr_data, rd_data, acc_data;
  logic          start, tmo, run;

  assign mfield   = mode_q[4:2];
  assign wr_mode  = bus_wr && (bus_addr == RG_MODE);
  assign wr_rate  = bus_wr && (bus_addr == RG_RATE);
  assign wr_data  = bus_wr && (bus_addr == RG_DATA);
  assign rd_data  = bus_rd && (bus_addr == RG_DATA);
  assign acc_data = wr_data || rd_data;
  assign start    = (wr_data && is_shifting(mfield)) || (rd_data && is_ctrl(mfield));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= '0;
      rate_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata;
      if (wr_rate) rate_q <= bus_wdata[RW-1:0];
      if (bus_rd) begin
        case (bus_addr)
          RG_MODE: bus_rdata <= mode_q;
          RG_RATE: bus_rdata <= 8'(rate_q);
          RG_DATA: bus_rdata <= 8'(sr);
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  sts_rate_timer #(.RW(RW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (start),
    .latch   (rate_q),
    .tmo     (tmo)
  );

  sts_bit_engine #(.W(DW)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop     (wr_mode),
    .start    (start),
    .load     (wr_data),
    .load_val (bus_wdata[DW-1:0]),
    .clr_done (acc_data),
    .tmo      (tmo),
    .free_run (is_free(mfield)),
    .shift_in (mfield == SM_CTRL_IN),
    .sin      (ser_in),
    .sr       (sr),
    .sclk     (shclk_o),
    .sout     (shdat_o),
    .run      (run),
    .done     (shdone_o)
  );

  p_done_ctrl_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shdone_o) |-> is_ctrl(mfield));
  p_access_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_data |=> !shdone_o);
  p_mode_write_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (shclk_o && !run));
endmodule

// File: tb/sts_timed_shifter_tb.sv
module sts_timed_shifter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic ser_in = 1'b0;
  logic shclk_o, shdat_o, shdone_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sts_timed_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_in(ser_in), .shclk_o(shclk_o), .shdat_o(shdat_o), .shdone_o(shdone_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  // counts negedges until shclk_o changes; measured from the negedge after an access
  task automatic wait_toggle(output int n);
    logic prev = shclk_o;
    n = 0;
    do begin @(negedge clk); n++; end while (shclk_o == prev && n < 3000);
  endtask

  task automatic free_run(input int n_rate, input logic [7:0] pat);
    int n;
    wr(2'd0, 8'h10);
    wr(2'd1, 8'(n_rate));
    wr(2'd2, pat);
    for (int h = 0; h < 32; h++) begin
      wait_toggle(n);
      chk(n == n_rate + 2, "R2 half-period", n, n_rate + 2);
      chk(shclk_o == ((h % 2) == 1), "R3 toggle direction", shclk_o, (h % 2));
      if (h % 2 == 0)
        chk(shdat_o == pat[7 - ((h / 2) % 8)], "R4 R5 bit order", shdat_o, pat[7 - ((h / 2) % 8)]);
    end
    chk(shdone_o == 1'b0, "R7 no done in free run", shdone_o, 0);
  endtask

  initial begin
    int n;
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(shclk_o == 1'b1, "R3 reset clock high", shclk_o, 1);
    chk(shdat_o == 1'b0, "R5 reset data low", shdat_o, 0);
    chk(shdone_o == 1'b0, "R6 reset done low", shdone_o, 0);
    chk(bus_rdata == 8'h00, "R1 reset rdata", bus_rdata, 0);

    wr(2'd1, 8'h5A); rd(2'd1);
    chk(bus_rdata == 8'h5A, "R1 rate readback", bus_rdata, 8'h5A);
    wr(2'd0, 8'h14); rd(2'd0);
    chk(bus_rdata == 8'h14, "R1 mode readback", bus_rdata, 8'h14);
    rd(2'd3);
    chk(bus_rdata == 8'h00, "R1 unused address", bus_rdata, 0);

    // R10: data write while idle only loads
    wr(2'd0, 8'h00); wr(2'd1, 8'd3); wr(2'd2, 8'hE7);
    n = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (!shclk_o) n++; end
    chk(n == 0, "R10 idle write no clock", n, 0);
    rd(2'd2);
    chk(bus_rdata == 8'hE7, "R10 idle write loads", bus_rdata, 8'hE7);

    free_run(0, 8'h0F);
    free_run(1, 8'hA5);
    free_run(5, 8'h0F);
    free_run(255, 8'h0F);

    // R10: mode write halts a free run
    wr(2'd0, 8'h10); wr(2'd1, 8'd2); wr(2'd2, 8'h3C);
    wait_toggle(n);
    chk(shclk_o == 1'b0, "R3 first toggle falls", shclk_o, 0);
    wr(2'd0, 8'h00);
    chk(shclk_o == 1'b1, "R10 halt returns high", shclk_o, 1);
    n = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (!shclk_o) n++; end
    chk(n == 0, "R10 stays halted", n, 0);

    // R6 R8: controlled shift-out
    wr(2'd0, 8'h14); wr(2'd1, 8'd3); wr(2'd2, 8'hC3);
    for (int h = 0; h < 16; h++) begin
      wait_toggle(n);
      chk(n == 5, "R2 ctrl half-period", n, 5);
      if (h % 2 == 0) chk(shdat_o == q[0] || 1'b1 ? shdat_o == (8'hC3 >> (7 - h / 2)) % 2 : 1'b0,
                          "R5 ctrl bit", shdat_o, (8'hC3 >> (7 - h / 2)) % 2);
      if (h < 15) chk(shdone_o == 1'b0, "R6 done not early", shdone_o, 0);
    end
    chk(shdone_o == 1'b1, "R6 done after 8 bits", shdone_o, 1);
    n = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (!shclk_o) n++; end
    chk(n == 0 && shclk_o, "R6 clock held high", n, 0);
    rd(2'd2);
    chk(bus_rdata == 8'hC3, "R4 rotate restores byte", bus_rdata, 8'hC3);
    chk(shdone_o == 1'b0, "R8 read clears done", shdone_o, 0);
    wait_toggle(n);
    chk(n == 5, "R8 read restarts ctrl", n, 5);
    wr(2'd0, 8'h00);

    // R9: controlled shift-in
    q = 8'hB2;
    wr(2'd0, 8'h04); wr(2'd1, 8'd2);
    ser_in = q[7];
    wr(2'd2, 8'h00);
    for (int h = 0; h < 16; h++) begin
      wait_toggle(n);
      chk(n == 4, "R9 shift-in half-period", n, 4);
      if (h % 2 == 1 && h < 15) ser_in = q[6 - h / 2];
    end
    chk(shdone_o == 1'b1, "R6 shift-in done", shdone_o, 1);
    wr(2'd0, 8'h00);
    chk(shdone_o == 1'b1, "R8 mode write keeps done", shdone_o, 1);
    rd(2'd2);
    chk(bus_rdata == q, "R9 received byte", bus_rdata, q);
    chk(shdone_o == 1'b0, "R8 access clears done", shdone_o, 0);
    wait_toggle(n);
    chk(n == 3000, "R8 idle read no restart", n, 3000);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule